// File: doc/BRIEF.md
# Multi-Source Reset Pulse Stretcher

This block collects reset requests from several places on a chip and turns any accepted one into a fixed-length, active-low pulse on a shared bidirectional reset pin. The always-honoured sources are power-on, low-voltage, illegal-address and the reset pin itself when something outside pulls it low. Two other sources are honoured only when their local enable allows them. A clock-monitor failure needs the oscillator enable bit. A watchdog timeout needs a nonzero 3-bit watchdog rate field.

The pin is driven low for a parameterised number of cycles, 512 by default. A new accepted source during the pulse starts the count again. When the pulse ends, the block samples the pin. If something outside still holds it low, that is taken as a new external reset. An internal system reset output stays asserted until the pin has been seen high for two consecutive samples.

A cause register records which sources have been accepted. A power-on event wipes every other cause bit.

Top module: `rst_pulse_gen`

## Requirements
- R1: After reset the pin drive is off, the system reset is asserted and the cause register is zero. An accepted power-on, low-voltage or illegal-address event, pulsed for one cycle, turns the pin drive on from the next cycle.
- R2: With no further source, the pin drive stays on for exactly PULSE_LEN (512) cycles and then turns off.
- R3: A clock-monitor event is ignored while osc_en is 0: no pin drive and no change to the cause register. It is accepted while osc_en is 1.
- R4: A watchdog event is ignored while wdog_rate is 3'b000: no pin drive and no change to the cause register. It is accepted for any nonzero rate.
- R5: An accepted source that arrives while the pin is being driven restarts the count, so the drive lasts PULSE_LEN cycles from that source.
- R6: When the block is not driving the pin, pin_in read low counts as an external reset. This includes the case where the pin is still held low from outside just after a pulse ends, which starts a new pulse.
- R7: Cause bits are bit0 power-on, bit1 low-voltage, bit2 external pin, bit3 illegal address, bit4 clock monitor and bit5 watchdog. Accepted sources set their bit and bits already set stay set. A power-on event leaves only bit0 set.
- R8: sys_rst deasserts only after the drive has ended and the pin has been sampled high on two consecutive cycles. When the pin rises as the drive ends, sys_rst is low from the fourth cycle after the drive turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL clock |
| rst_n | input | 1 | Asynchronous initialisation of the block's flops, active low |
| por_evt | input | 1 | Power-on reset event, one-cycle pulse |
| lvr_evt | input | 1 | Low-voltage reset event |
| illegal_evt | input | 1 | Illegal-address reset event |
| clkmon_evt | input | 1 | Clock-monitor failure event |
| wdog_evt | input | 1 | Watchdog timeout event |
| osc_en | input | 1 | Oscillator enable; gates clkmon_evt |
| wdog_rate | input | 3 | Watchdog rate; zero gates wdog_evt |
| pin_in | input | 1 | Level read back from the reset pin |
| pin_drive_en | output | 1 | 1 = drive the reset pin low |
| sys_rst | output | 1 | Internal system reset, active high |
| cause | output | 6 | Accepted reset causes |

## Verification
The assertions assume that the event inputs are synchronous to clk. They also assume that pin_in reads low whenever pin_drive_en is high, and that an external holder can only pull the pin low. The pulse-length property counts from the last gated source it can see at the ports. It relies on external resets never being accepted during a drive, which holds when the pin model is a wired-AND of the block and the outside holder. The bench builds pin_in in exactly that way. It changes every input at the falling clock edge and gives each event a single-cycle pulse.

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int PULSE_LEN = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_evt,
  input  logic       lvr_evt,
  input  logic       illegal_evt,
  input  logic       clkmon_evt,
  input  logic       wdog_evt,
  input  logic       osc_en,
  input  logic [2:0] wdog_rate,
  input  logic       pin_in,
  output logic       pin_drive_en,
  output logic       sys_rst,
  output logic [5:0] cause
);
  localparam int CW = $clog2(PULSE_LEN);

  logic [CW-1:0] cnt;
  logic          active, active_d, pin_q;
  logic [1:0]    hi_cnt;
  logic          ext_src;
  logic [5:0]    accepted;

  assign ext_src  = ~pin_q & ~active & ~active_d;
  assign accepted = {wdog_evt & (|wdog_rate), clkmon_evt & osc_en, illegal_evt,
                     ext_src, lvr_evt, por_evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      active_d <= 1'b0;
      cnt      <= '0;
      pin_q    <= 1'b1;
      hi_cnt   <= 2'd0;
      cause    <= '0;
    end else begin
      active_d <= active;
      pin_q    <= pin_in;
      if (|accepted) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active) begin
        if (cnt == CW'(PULSE_LEN - 1)) active <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
      if (active || !pin_q) hi_cnt <= 2'd0;
      else if (hi_cnt != 2'd2) hi_cnt <= hi_cnt + 2'd1;
      if (por_evt) cause <= 6'b000001;
      else cause <= cause | accepted;
    end
  end

  assign pin_drive_en = active;
  assign sys_rst      = active | (hi_cnt != 2'd2);

  logic [CW:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (por_evt | lvr_evt | illegal_evt | (clkmon_evt & osc_en) | (wdog_evt & (|wdog_rate)))
      run <= '0;
    else if (pin_drive_en) run <= run + 1'b1;
    else run <= '0;
  end

  a_r1_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
    (por_evt | lvr_evt | illegal_evt) |=> pin_drive_en);
  a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_drive_en) |-> run == (CW+1)'(PULSE_LEN));
  a_r3_clkmon_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !$rose(cause[4]));
  a_r4_wdog_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_rate == 3'd0) |=> !$rose(cause[5]));
  a_r5_restart_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_drive_en & lvr_evt) |=> pin_drive_en);
  a_r6_ext_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause[2]) |-> !$past(pin_in, 2));
  a_r7_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> cause == 6'b000001);
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> !pin_drive_en && $past(pin_in, 2) && $past(pin_in, 3));
endmodule

// File: tb/rst_pulse_gen_test.sv
module rst_pulse_gen_test;
  logic clk = 0;
  logic rst_n = 0;
  logic por_evt = 0, lvr_evt = 0, illegal_evt = 0, clkmon_evt = 0, wdog_evt = 0;
  logic osc_en = 0;
  logic [2:0] wdog_rate = 3'd0;
  logic ext_hold = 0;
  logic pin_in;
  logic pin_drive_en, sys_rst;
  logic [5:0] cause;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign pin_in = ~(pin_drive_en | ext_hold);

  rst_pulse_gen uut (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .lvr_evt(lvr_evt),
    .illegal_evt(illegal_evt), .clkmon_evt(clkmon_evt), .wdog_evt(wdog_evt),
    .osc_en(osc_en), .wdog_rate(wdog_rate), .pin_in(pin_in),
    .pin_drive_en(pin_drive_en), .sys_rst(sys_rst), .cause(cause)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: por_evt = 1; 1: lvr_evt = 1; 3: illegal_evt = 1;
      4: clkmon_evt = 1; default: wdog_evt = 1;
    endcase
    @(negedge clk);
    por_evt = 0; lvr_evt = 0; illegal_evt = 0; clkmon_evt = 0; wdog_evt = 0;
  endtask

  task automatic measure(output int len);
    len = 0;
    while (pin_drive_en) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic tail_check();
    int seen[4];
    for (int i = 0; i < 4; i++) begin
      seen[i] = sys_rst;
      if (i < 3) @(negedge clk);
    end
    chk("R8 sys_rst n1", seen[0], 1);
    chk("R8 sys_rst n3", seen[2], 1);
    chk("R8 sys_rst n4", seen[3], 0);
  endtask

  task automatic t_reset();
    chk("R1 reset drive", pin_drive_en, 0);
    chk("R1 reset sys_rst", sys_rst, 1);
    chk("R1 reset cause", cause, 0);
  endtask

  task automatic t_por();
    int len;
    pulse(0);
    chk("R1 por drive", pin_drive_en, 1);
    measure(len);
    chk("R2 por length", len, 512);
    chk("R7 por cause", cause, 6'b000001);
    tail_check();
  endtask

  task automatic t_clkmon();
    int len;
    osc_en = 0;
    pulse(4);
    repeat (3) @(negedge clk);
    chk("R3 clkmon ignored drive", pin_drive_en, 0);
    chk("R3 clkmon ignored cause", cause, 6'b000001);
    osc_en = 1;
    pulse(4);
    chk("R3 clkmon accepted", pin_drive_en, 1);
    measure(len);
    chk("R3 clkmon cause", cause, 6'b010001);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_wdog();
    int len;
    wdog_rate = 3'd0;
    pulse(5);
    repeat (3) @(negedge clk);
    chk("R4 wdog ignored drive", pin_drive_en, 0);
    chk("R4 wdog ignored cause", cause, 6'b010001);
    wdog_rate = 3'd3;
    pulse(5);
    chk("R4 wdog accepted", pin_drive_en, 1);
    measure(len);
    chk("R4 wdog length", len, 512);
    chk("R7 accumulate", cause, 6'b110001);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_restart();
    int len;
    pulse(3);
    repeat (100) @(negedge clk);
    pulse(1);
    measure(len);
    chk("R5 restart length", len, 512);
    chk("R7 lvr+ill cause", cause, 6'b111011);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ext();
    int len;
    @(negedge clk); ext_hold = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 ext accepted", pin_drive_en, 1);
    ext_hold = 0;
    measure(len);
    chk("R6 ext length", len, 512);
    chk("R6 ext cause", cause[2], 1);
    tail_check();
    pulse(3);
    ext_hold = 1;
    measure(len);
    @(negedge clk);
    chk("R6 hold after release n2", pin_drive_en, 0);
    @(negedge clk);
    chk("R6 hold after release n3", pin_drive_en, 1);
    chk("R8 held pin keeps sys_rst", sys_rst, 1);
    ext_hold = 0;
    measure(len);
    chk("R6 re-pulse length", len, 512);
    tail_check();
  endtask

  task automatic t_por_clear();
    int len;
    pulse(0);
    chk("R7 por clears others", cause, 6'b000001);
    measure(len);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_por();
    t_clkmon();
    t_wdog();
    t_restart();
    t_ext();
    t_por_clear();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule